// File: doc/BRIEF.md
# Change-of-Flow Trace Buffer with Loop Filtering

This block records program-flow history in a circular on-chip store so that a debugger can later see the path the CPU took. It watches a CPU event interface. One group of signals carries change-of-flow strobes, each with an address and a kind: source, destination or vector. A second group carries plain memory or register accesses, each with an address and data. A mode input selects what is captured. Normal mode keeps every change-of-flow event. Loop-filter mode drops a source address that repeats the last stored address, so a polling or delay loop cannot fill the store. Detail mode keeps the address and data of every access.

Capture runs while the arm input is held high. A rising edge on arm starts a fresh recording: it empties the store and invalidates the shadow register that remembers the last stored address. The debugger walks the entries through a read pointer. That pointer can be rewound to the oldest entry and stepped forward one entry at a time. Capture pauses while the debugger signals that it is reading.

Top module: `flow_trace_buf`

## Requirements
- R1: After reset, entryCount is 0.
- R2: While armIn is low, no event is stored. The cycle in which armIn is first sampled high empties the store and invalidates the shadow. Events are stored only from the following cycle on.
- R3: In normal mode (modeSel 00) and in modeSel 11, each cofValid strobe is stored as one entry, in arrival order. The entry holds the tag, equal to the cofKind code (00 source, 01 destination, 10 vector), and cofAddr, with data 0. A strobe with cofKind 11 is ignored. The entry is readable after the clock edge that samples the strobe.
- R4: In loop-filter mode (modeSel 01), a source event whose address equals the shadow is discarded. A polling loop that repeats one source address therefore stores a single entry.
- R5: In loop-filter mode, destination and vector events are never discarded, even when they repeat. An interrupt taken during a jump therefore yields, in order: jump destination, vector, return destination, next source.
- R6: Every stored address is copied into the shadow, whatever its tag. A source address is stored again once a different entry has been stored after it.
- R7: In detail mode (modeSel 10), each accValid strobe is stored with tag 11, accAddr and accData, and cofValid strobes are ignored. In the other modes, accValid strobes are ignored.
- R8: The store holds DEPTH (64) entries. The write pointer wraps, so the oldest entry is overwritten, and entryCount saturates at DEPTH.
- R9: A rdRewind pulse points the read port at the oldest stored entry. Each rdStep pulse advances it by one entry, wrapping at the end. rdTag, rdAddr and rdData show the selected entry combinationally.
- R10: While rdActive is high, no event is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armIn | input | 1 | Capture enable; a rising edge starts a new recording |
| modeSel | input | 2 | 00 normal, 01 loop filter, 10 detail, 11 normal |
| cofValid | input | 1 | Change-of-flow event strobe |
| cofKind | input | 2 | 00 source, 01 destination, 10 vector |
| cofAddr | input | 16 | Change-of-flow address |
| accValid | input | 1 | Memory/register access strobe |
| accAddr | input | 16 | Access address |
| accData | input | 16 | Access data |
| rdActive | input | 1 | Debugger is reading; capture is held off |
| rdRewind | input | 1 | Move the read pointer to the oldest entry |
| rdStep | input | 1 | Advance the read pointer by one |
| rdTag | output | 2 | Tag of the selected entry |
| rdAddr | output | 16 | Address of the selected entry |
| rdData | output | 16 | Data of the selected entry (detail entries only) |
| entryCount | output | 7 | Number of valid entries, saturating at DEPTH |

## Verification
An event strobe is registered on the one clock edge that samples it. Its entry and the new entryCount are therefore due one edge after the strobe is driven. A rewind or step moves the read pointer on its sampling edge, and the read fields follow it combinationally. Arming takes one edge to reset the store before the first event can be stored. The bench drives every input on the falling edge and samples on the next falling edge, so each check sees exactly one registered update. Filtered or ignored events are checked through entryCount and by walking the whole store.

// File: rtl/flow_trace_pkg.sv
package flow_trace_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    TAG_SRC = 2'b00,
    TAG_DST = 2'b01,
    TAG_VEC = 2'b10,
    TAG_ACC = 2'b11
  } tag_e;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_LOOP   = 2'b01,
    MODE_DETAIL = 2'b10,
    MODE_ALT    = 2'b11
  } mode_e;

  typedef struct packed {
    tag_e              tag;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } entry_t;

  // control -> datapath strobes
  typedef struct packed {
    logic wrEn;
    logic restart;
    logic rewind;
    logic step;
  } strobe_t;

endpackage

// File: rtl/flow_trace_filter.sv
module flow_trace_filter #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clearShadow,
  input  logic          loadShadow,
  input  logic [AW-1:0] addrIn,
  input  logic          probeEn,
  output logic          hit
);

  logic          shadowValid;
  logic [AW-1:0] shadowAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowValid <= 1'b0;
      shadowAddr  <= '0;
    end else if (clearShadow) begin
      shadowValid <= 1'b0;
    end else if (loadShadow) begin
      shadowValid <= 1'b1;
      shadowAddr  <= addrIn;
    end
  end

  assign hit = probeEn && shadowValid && (addrIn == shadowAddr);

endmodule

// File: rtl/flow_trace_ctrl.sv
module flow_trace_ctrl
  import flow_trace_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              armIn,
  input  logic [1:0]        modeSel,
  input  logic              cofValid,
  input  logic [1:0]        cofKind,
  input  logic [ADDR_W-1:0] cofAddr,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accData,
  input  logic              rdActive,
  input  logic              rdRewind,
  input  logic              rdStep,
  output strobe_t           stb,
  output entry_t            wrEntry
);

  logic   armQ;
  logic   armRise;
  logic   captureOn;
  logic   candValid;
  logic   filterHit;
  logic   probeEn;
  mode_e  mode;
  entry_t cand;

  always_ff @(posedge clk) begin
    if (!rstN) armQ <= 1'b0;
    else       armQ <= armIn;
  end

  assign mode      = mode_e'(modeSel);
  assign armRise   = armIn && !armQ;
  assign captureOn = armIn && armQ && !rdActive;

  // select the candidate entry for this cycle
  always_comb begin
    if (mode == MODE_DETAIL) begin
      candValid = accValid;
      cand.tag  = TAG_ACC;
      cand.addr = accAddr;
      cand.data = accData;
    end else begin
      candValid = cofValid && (cofKind != 2'b11);
      cand.tag  = tag_e'(cofKind);
      cand.addr = cofAddr;
      cand.data = '0;
    end
  end

  // only sources are subject to loop filtering
  assign probeEn = (mode == MODE_LOOP) && candValid && (cand.tag == TAG_SRC);

  flow_trace_filter #(.AW(ADDR_W)) uFilter (
    .clk         (clk),
    .rstN        (rstN),
    .clearShadow (armRise),
    .loadShadow  (stb.wrEn),
    .addrIn      (cand.addr),
    .probeEn     (probeEn),
    .hit         (filterHit)
  );

  always_comb begin
    stb.wrEn    = captureOn && candValid && !filterHit;
    stb.restart = armRise;
    stb.rewind  = rdRewind;
    stb.step    = rdStep && !rdRewind;
  end

  assign wrEntry = cand;

endmodule

// File: rtl/flow_trace_store.sv
module flow_trace_store
  import flow_trace_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      stb,
  input  entry_t                       wrEntry,
  output entry_t                       rdEntry,
  output logic [$clog2(DEPTH+1)-1:0]   entryCount
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  entry_t            mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  count;
  logic              doWrite;

  function automatic logic [PTR_W-1:0] nextIdx(input logic [PTR_W-1:0] idx);
    return (idx == LAST_IDX) ? '0 : idx + 1'b1;
  endfunction

  assign doWrite = stb.wrEn && !stb.restart;

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      count <= '0;
    end else if (stb.restart) begin
      wrPtr <= '0;
      count <= '0;
    end else if (doWrite) begin
      wrPtr <= nextIdx(wrPtr);
      if (count != FULL_CNT) count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
    end else if (stb.rewind) begin
      rdPtr <= (count == FULL_CNT) ? wrPtr : '0;
    end else if (stb.step) begin
      rdPtr <= nextIdx(rdPtr);
    end
  end

  assign rdEntry    = mem[rdPtr];
  assign entryCount = count;

endmodule

// File: rtl/flow_trace_buf.sv
module flow_trace_buf
  import flow_trace_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       armIn,
  input  logic [1:0]                 modeSel,
  input  logic                       cofValid,
  input  logic [1:0]                 cofKind,
  input  logic [15:0]                cofAddr,
  input  logic                       accValid,
  input  logic [15:0]                accAddr,
  input  logic [15:0]                accData,
  input  logic                       rdActive,
  input  logic                       rdRewind,
  input  logic                       rdStep,
  output logic [1:0]                 rdTag,
  output logic [15:0]                rdAddr,
  output logic [15:0]                rdData,
  output logic [$clog2(DEPTH+1)-1:0] entryCount
);

  strobe_t stb;
  entry_t  wrEntry;
  entry_t  rdEntry;
  logic    wrStrobe;
  logic    restartStrobe;

  flow_trace_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .armIn    (armIn),
    .modeSel  (modeSel),
    .cofValid (cofValid),
    .cofKind  (cofKind),
    .cofAddr  (cofAddr),
    .accValid (accValid),
    .accAddr  (accAddr),
    .accData  (accData),
    .rdActive (rdActive),
    .rdRewind (rdRewind),
    .rdStep   (rdStep),
    .stb      (stb),
    .wrEntry  (wrEntry)
  );

  flow_trace_store #(.DEPTH(DEPTH)) uStore (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrEntry    (wrEntry),
    .rdEntry    (rdEntry),
    .entryCount (entryCount)
  );

  assign rdTag         = rdEntry.tag;
  assign rdAddr        = rdEntry.addr;
  assign rdData        = rdEntry.data;
  assign wrStrobe      = stb.wrEn;
  assign restartStrobe = stb.restart;

endmodule

// File: rtl/flow_trace_chk.sv
module flow_trace_chk #(
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       armIn,
  input logic                       rdActive,
  input logic                       wrStrobe,
  input logic                       restartStrobe,
  input logic [$clog2(DEPTH+1)-1:0] entryCount
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    entryCount <= FULL_CNT);

  a_r8_count_steps: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && entryCount != FULL_CNT) |=> entryCount == $past(entryCount) + 1'b1);

  a_r8_count_holds_full: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && entryCount == FULL_CNT) |=> entryCount == FULL_CNT);

  a_r2_idle_when_disarmed: assert property (@(posedge clk) disable iff (!rstN)
    !armIn |=> $stable(entryCount));

  a_r2_restart_empties: assert property (@(posedge clk) disable iff (!rstN)
    restartStrobe |=> entryCount == '0);

  a_r10_no_write_while_reading: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (armIn && !rdActive));

endmodule

bind flow_trace_buf flow_trace_chk #(.DEPTH(DEPTH)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .armIn         (armIn),
  .rdActive      (rdActive),
  .wrStrobe      (wrStrobe),
  .restartStrobe (restartStrobe),
  .entryCount    (entryCount)
);

// File: tb/sim_flow_trace_buf.sv
`timescale 1ns/1ps
module sim_flow_trace_buf;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        armIn = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic        cofValid = 1'b0;
  logic [1:0]  cofKind = 2'b00;
  logic [15:0] cofAddr = '0;
  logic        accValid = 1'b0;
  logic [15:0] accAddr = '0;
  logic [15:0] accData = '0;
  logic        rdActive = 1'b0;
  logic        rdRewind = 1'b0;
  logic        rdStep = 1'b0;
  logic [1:0]  rdTag;
  logic [15:0] rdAddr;
  logic [15:0] rdData;
  logic [6:0]  entryCount;

  int errors = 0;
  int checks = 0;

  logic [1:0]  eTag  [80];
  logic [15:0] eAddr [80];
  logic [15:0] eData [80];
  int          eN = 0;

  always #4 clk = ~clk;

  flow_trace_buf #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .armIn(armIn), .modeSel(modeSel),
    .cofValid(cofValid), .cofKind(cofKind), .cofAddr(cofAddr),
    .accValid(accValid), .accAddr(accAddr), .accData(accData),
    .rdActive(rdActive), .rdRewind(rdRewind), .rdStep(rdStep),
    .rdTag(rdTag), .rdAddr(rdAddr), .rdData(rdData), .entryCount(entryCount)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic arm(input logic [1:0] mode);
    @(negedge clk); armIn = 1'b0;
    @(negedge clk); armIn = 1'b1; modeSel = mode;
    @(negedge clk);
    eN = 0;
  endtask

  task automatic cof(input logic [1:0] kind, input logic [15:0] addr);
    cofValid = 1'b1; cofKind = kind; cofAddr = addr;
    @(negedge clk);
    cofValid = 1'b0;
  endtask

  task automatic acc(input logic [15:0] addr, input logic [15:0] data);
    accValid = 1'b1; accAddr = addr; accData = data;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic expect_entry(input logic [1:0] tag, input logic [15:0] addr, input logic [15:0] data);
    eTag[eN] = tag; eAddr[eN] = addr; eData[eN] = data;
    eN++;
  endtask

  task automatic walk(input string req);
    check(req, "entryCount", int'(entryCount), eN);
    rdRewind = 1'b1;
    @(negedge clk); rdRewind = 1'b0;
    for (int i = 0; i < eN; i++) begin
      check(req, $sformatf("tag[%0d]", i), int'(rdTag), int'(eTag[i]));
      check(req, $sformatf("addr[%0d]", i), int'(rdAddr), int'(eAddr[i]));
      check(req, $sformatf("data[%0d]", i), int'(rdData), int'(eData[i]));
      rdStep = 1'b1;
      @(negedge clk); rdStep = 1'b0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "entryCount after reset", int'(entryCount), 0);
  endtask

  task automatic t_disarmed();
    armIn = 1'b0;
    @(negedge clk);
    cof(2'b00, 16'h1111);
    cof(2'b01, 16'h2222);
    check("R2", "count while disarmed", int'(entryCount), 0);
  endtask

  task automatic t_normal();
    arm(2'b00);
    check("R2", "count after arming", int'(entryCount), 0);
    cof(2'b00, 16'h1000); expect_entry(2'b00, 16'h1000, 16'h0);
    cof(2'b01, 16'h2000); expect_entry(2'b01, 16'h2000, 16'h0);
    cof(2'b00, 16'h1000); expect_entry(2'b00, 16'h1000, 16'h0);
    cof(2'b00, 16'h1000); expect_entry(2'b00, 16'h1000, 16'h0);
    acc(16'h0400, 16'h5555);            // R7: ignored outside detail mode
    cof(2'b11, 16'h3333);               // R3: kind 11 ignored
    cof(2'b10, 16'hFFF2); expect_entry(2'b10, 16'hFFF2, 16'h0);
    walk("R3");
  endtask

  task automatic t_alt_mode();
    arm(2'b11);
    cof(2'b00, 16'h0ABC); expect_entry(2'b00, 16'h0ABC, 16'h0);
    cof(2'b00, 16'h0ABC); expect_entry(2'b00, 16'h0ABC, 16'h0);
    walk("R3");
  endtask

  task automatic t_loop();
    arm(2'b01);
    check("R2", "count after re-arm", int'(entryCount), 0);
    for (int i = 0; i < 5; i++) cof(2'b00, 16'h3000);
    expect_entry(2'b00, 16'h3000, 16'h0);
    check("R4", "polling loop stores once", int'(entryCount), 1);
    for (int i = 0; i < 3; i++) begin
      cof(2'b01, 16'h4000); expect_entry(2'b01, 16'h4000, 16'h0);
    end
    for (int i = 0; i < 3; i++) begin
      cof(2'b10, 16'hFFF2); expect_entry(2'b10, 16'hFFF2, 16'h0);
    end
    check("R5", "repeated dst/vec kept", int'(entryCount), 7);
    cof(2'b00, 16'h3000); expect_entry(2'b00, 16'h3000, 16'h0);
    check("R6", "source stored after other entry", int'(entryCount), 8);
    walk("R4");
  endtask

  task automatic t_irq_order();
    arm(2'b01);
    cof(2'b01, 16'h6100); expect_entry(2'b01, 16'h6100, 16'h0);
    cof(2'b10, 16'hFFF2); expect_entry(2'b10, 16'hFFF2, 16'h0);
    cof(2'b01, 16'h6100); expect_entry(2'b01, 16'h6100, 16'h0);
    cof(2'b00, 16'h6104); expect_entry(2'b00, 16'h6104, 16'h0);
    walk("R5");
  endtask

  task automatic t_detail();
    arm(2'b10);
    acc(16'h0800, 16'hAB12); expect_entry(2'b11, 16'h0800, 16'hAB12);
    cof(2'b00, 16'h7000);    // R7: ignored in detail mode
    acc(16'h0802, 16'h3344); expect_entry(2'b11, 16'h0802, 16'h3344);
    acc(16'h0800, 16'hAB12); expect_entry(2'b11, 16'h0800, 16'hAB12);
    walk("R7");
  endtask

  task automatic t_reading();
    arm(2'b00);
    rdActive = 1'b1;
    cof(2'b00, 16'h9000);
    cof(2'b01, 16'h9002);
    rdActive = 1'b0;
    check("R10", "count while reading", int'(entryCount), 0);
    cof(2'b00, 16'h9004); expect_entry(2'b00, 16'h9004, 16'h0);
    walk("R10");
  endtask

  task automatic t_wrap();
    arm(2'b00);
    for (int i = 0; i < 70; i++) cof(2'b01, 16'h8000 + 16'(i));
    check("R8", "count saturates", int'(entryCount), DEPTH);
    for (int i = 0; i < DEPTH; i++) expect_entry(2'b01, 16'h8000 + 16'(i + 6), 16'h0);
    walk("R8");
    check("R9", "wrapped back to oldest", int'(rdAddr), 16'h8006);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired: actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_disarmed();
    t_normal();
    t_alt_mode();
    t_loop();
    t_irq_order();
    t_detail();
    t_reading();
    t_wrap();
    summary();
  end

endmodule